// File: doc/BRIEF.md
# Periodic Wake Timer with Acknowledge Watchdog

This block generates a periodic wake pulse for a host processor and checks that the host acknowledges each interval. All timing is counted in ticks of a slow oscillator. The ticks arrive as a one-cycle enable on the system clock. After power-on the block samples an interval configuration bus once, on the first tick. That value, raised to a fixed minimum, sets the number of ticks between successive wake rising edges. Until that sample is taken, the active-low reset output stays low.

In each interval the host must raise its acknowledge input. The acknowledge must arrive more than a guard time before the next scheduled wake edge. If it does, the block issues the next wake pulse. If it does not, the block drives reset low for a fixed number of ticks at the interval boundary instead, then restarts its interval counting from zero. The host can also force a reset through a manual-reset input. That input counts only when it is seen high on two consecutive ticks. Both host inputs are asynchronous and pass through two-flop synchronizers.

The wake pulse width, reset pulse width and guard time are parameters counted in ticks.

Top module: `wake_watchdog_timer`

## Requirements
- R1: After power-on reset is released, `rst_n_o` stays low until the first tick, and goes high on that tick, when `cfg_i` is sampled.
- R2: `cfg_i` is sampled only once after power-on. Changing it later leaves the interval unchanged.
- R3: While every interval is acknowledged, `wake_o` rising edges are exactly P ticks apart. The first wake rising edge comes P ticks after `rst_n_o` rises. P is the sampled value after the clamp of R10.
- R4: `mrst_i` high on two consecutive ticks drives `rst_n_o` low on the second of those ticks. A high seen on one tick only has no effect.
- R5: At an interval boundary with no accepted acknowledge, `rst_n_o` falls and no wake pulse is issued.
- R6: After any reset falling edge, the next reset falling edge or wake rising edge comes exactly RST_W + P ticks later. The interval counters restart.
- R7: A wake pulse lasts WAKE_W ticks (default 2). A reset pulse lasts RST_W ticks (default 2).
- R8: Counting ticks from the interval start at 0, an acknowledge rising edge is accepted only when the current tick index is below P - GUARD (GUARD default 2). An acknowledge at a later index is ignored.
- R9: An accepted acknowledge is cleared at each wake rising edge, so every interval needs a fresh one.
- R10: A sampled value below GUARD + WAKE_W is raised to GUARD + WAKE_W.
- R11: `wake_o` is never high while `rst_n_o` is low, and both outputs change only on tick edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | One-cycle enable per slow oscillator period |
| done_i | input | 1 | Host acknowledge, asynchronous, rising-edge sensitive |
| mrst_i | input | 1 | Manual reset request, asynchronous, active high |
| cfg_i | input | CFG_W | Interval in ticks, sampled once after power-on |
| wake_o | output | 1 | Periodic wake pulse |
| rst_n_o | output | 1 | Active-low reset to the host |

## Verification
The assertions assume that `tick` is high for single clock cycles that are separated by several idle cycles. They also assume that the host inputs are held for longer than the synchronizer latency. The bench raises `tick` for one clock in every four. It changes `done_i` and `mrst_i` only between ticks and holds each level for four clocks, so every edge settles before the next tick samples it. The sweep covers sampled values below, at and above the clamp minimum, up to the bus maximum. For each value it places acknowledges at the last legal index and at the first guarded index.

// File: rtl/wake_watchdog_timer.sv
module wake_watchdog_timer #(
  parameter int CFG_W  = 6,
  parameter int GUARD  = 2,
  parameter int WAKE_W = 2,
  parameter int RST_W  = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tick,
  input  logic             done_i,
  input  logic             mrst_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             wake_o,
  output logic             rst_n_o
);
  localparam int CW    = CFG_W + 4;
  localparam int MIN_P = GUARD + WAKE_W;

  typedef enum logic [1:0] {CAP, RSTP, RUN} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt, per;
  logic          ack, woke, mr_held, dn_q;
  logic [1:0]    dn_sy, mr_sy;

  wire [CW-1:0] cfg_w   = CW'(cfg_i);
  wire [CW-1:0] per_new = (cfg_w < CW'(MIN_P)) ? CW'(MIN_P) : cfg_w;
  wire running  = (phase == RUN);
  wire captured = (phase != CAP);
  wire last     = (cnt == per - CW'(1));
  wire in_win   = running && (cnt < per - CW'(GUARD));
  wire dn_rise  = dn_sy[1] & ~dn_q;
  wire mr_ok    = mr_sy[1] & mr_held;

  assign rst_n_o = running;
  assign wake_o  = running && woke && (cnt < CW'(WAKE_W));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dn_sy   <= '0;
      mr_sy   <= '0;
      dn_q    <= 1'b0;
      mr_held <= 1'b0;
    end else begin
      dn_sy <= {dn_sy[0], done_i};
      mr_sy <= {mr_sy[0], mrst_i};
      dn_q  <= dn_sy[1];
      if (tick) mr_held <= mr_sy[1];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase <= CAP;
      cnt   <= '0;
      per   <= CW'(MIN_P);
      ack   <= 1'b0;
      woke  <= 1'b0;
    end else begin
      if (dn_rise && in_win) ack <= 1'b1;
      if (tick) begin
        case (phase)
          CAP: begin
            per   <= per_new;
            phase <= RUN;
            cnt   <= '0;
            ack   <= 1'b0;
            woke  <= 1'b0;
          end
          RSTP: begin
            if (cnt == CW'(RST_W - 1)) begin
              phase <= RUN;
              cnt   <= '0;
              woke  <= 1'b0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: begin
            if (mr_ok) begin
              phase <= RSTP;
              cnt   <= '0;
              ack   <= 1'b0;
              woke  <= 1'b0;
            end else if (last) begin
              cnt <= '0;
              ack <= 1'b0;
              if (ack) begin
                woke <= 1'b1;
              end else begin
                phase <= RSTP;
                woke  <= 1'b0;
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        endcase
      end
    end
  end
endmodule

module wwt_props #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         por_n,
  input logic         tick,
  input logic         wake_o,
  input logic         rst_n_o,
  input logic         ack,
  input logic [W-1:0] per,
  input logic         captured
);
  // R1
  rst_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n_o) |-> $past(tick));

  // R5
  rst_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_n_o) |-> $past(tick));

  // R2
  per_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (captured && $past(captured)) |-> $stable(per));

  // R11
  wake_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(wake_o) |-> $past(tick));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(wake_o && !rst_n_o));

  // R9
  ack_fresh_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wake_o) |-> !ack);
endmodule

bind wake_watchdog_timer wwt_props #(.W(CFG_W + 4)) u_props (
  .clk(clk), .por_n(por_n), .tick(tick), .wake_o(wake_o), .rst_n_o(rst_n_o),
  .ack(ack), .per(per), .captured(captured)
);

// File: tb/wake_watchdog_timer_tb.sv
`timescale 1ns/1ps
module wake_watchdog_timer_tb;
  localparam int CFG_W  = 6;
  localparam int GUARD  = 2;
  localparam int WAKE_W = 2;
  localparam int RST_W  = 2;
  localparam int MIN_P  = GUARD + WAKE_W;

  logic clk = 1'b0, por_n = 1'b0, tick = 1'b0, done_i = 1'b0, mrst_i = 1'b0;
  logic [CFG_W-1:0] cfg_i = '0;
  logic wake_o, rst_n_o;
  int errs = 0, chks = 0, P = MIN_P;

  wake_watchdog_timer #(.CFG_W(CFG_W), .GUARD(GUARD), .WAKE_W(WAKE_W), .RST_W(RST_W)) u_dut (
    .clk(clk), .por_n(por_n), .tick(tick), .done_i(done_i), .mrst_i(mrst_i),
    .cfg_i(cfg_i), .wake_o(wake_o), .rst_n_o(rst_n_o));

  always #2.5 clk = ~clk;

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic tk();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk(input bit er, input bit ew, input string tag);
    chks++;
    if (rst_n_o !== er || wake_o !== ew) begin
      errs++;
      $display("FAIL %s P=%0d: rst_n=%0b wake=%0b expected rst_n=%0b wake=%0b",
               tag, P, rst_n_o, wake_o, er, ew);
    end
  endtask

  task automatic st(input bit er, input bit ew, input string tag);
    tk();
    chk(er, ew, tag);
  endtask

  task automatic ack_pulse();
    done_i = 1'b1; settle();
    done_i = 1'b0; settle();
  endtask

  task automatic reset_tail(input string tag);
    for (int j = 0; j < RST_W - 1; j++) st(1'b0, 1'b0, {tag, " R7 reset width"});
    st(1'b1, 1'b0, {tag, " R6 reset release"});
  endtask

  task automatic interval(input int ack_at, input bit woke, input string tag);
    bit ok;
    ok = (ack_at >= 0) && (ack_at < P - GUARD);
    for (int k = 0; k < P; k++) begin
      if (k == ack_at) ack_pulse();
      tk();
      if (k < P - 1) chk(1'b1, woke && (k + 1 < WAKE_W), {tag, " R7 mid"});
      else           chk(ok, ok, {tag, " R5 boundary"});
    end
    if (!ok) reset_tail(tag);
  endtask

  initial begin
    int vals[6] = '{0, 3, 4, 5, 9, 63};
    foreach (vals[i]) begin
      P = (vals[i] < MIN_P) ? MIN_P : vals[i];
      por_n = 1'b0; cfg_i = CFG_W'(vals[i]); done_i = 1'b0; mrst_i = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      settle();
      chk(1'b0, 1'b0, "R1 before capture");
      st(1'b1, 1'b0, "R1 after capture");
      cfg_i = ~cfg_i;
      interval(0, 1'b0, "R3 R10 first");
      interval(1, 1'b1, "R3 R2 periodic");
      interval(P - GUARD - 1, 1'b1, "R8 last legal");
      interval(P - GUARD, 1'b1, "R8 guard ignored");
      interval(-1, 1'b0, "R6 no ack after reset");
      interval(0, 1'b0, "R6 recovery");
      interval(-1, 1'b1, "R9 stale ack");
      ack_pulse();
      mrst_i = 1'b1; settle();
      st(1'b1, 1'b0, "R4 glitch sample");
      mrst_i = 1'b0; settle();
      st(1'b1, 1'b0, "R4 glitch ignored");
      for (int k = 2; k < P; k++) begin
        tk();
        if (k < P - 1) chk(1'b1, 1'b0, "R4 after glitch");
        else           chk(1'b1, 1'b1, "R4 wake after glitch");
      end
      mrst_i = 1'b1; settle();
      st(1'b1, (1 < WAKE_W), "R4 held first");
      st(1'b0, 1'b0, "R4 held second");
      mrst_i = 1'b0; settle();
      reset_tail("R4");
      interval(0, 1'b0, "R6 after manual");
    end
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++; chks++;
    $display("FAIL R3 watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule